// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block picks the fastest DMA transfer mode that both a storage device and its host controller can use. It takes capability bit masks from each side, two capability-valid flags, a legacy single-word timing value, a cable flag and a requested mode code. On a start pulse it searches three transfer classes in a fixed priority order. Ultra DMA is tried first, then multiword DMA, then singleword DMA. It returns a mode code, or zero when no DMA mode fits.

Mode codes are 8 bits wide. Ultra DMA mode n is 0x40 + n, multiword DMA mode n is 0x20 + n and singleword DMA mode n is 0x10 + n. A class is only searched when the requested code is at least its base. Within a class the chosen mode is the highest bit set in the AND of the host mask and the device mask. Ultra modes above 2 need a detected 80-wire cable. The chosen code is then limited to the requested code.

The control is a two-state machine:
- `S_IDLE`: no result is being presented.
- `S_PRESENT`: `mode_valid` is high for one cycle.

It has three transitions:
- `T_LAUNCH`: from `S_IDLE` to `S_PRESENT` when `start` is high.
- `T_REPEAT`: stays in `S_PRESENT` when `start` is high again.
- `T_RETIRE`: from `S_PRESENT` back to `S_IDLE` when `start` is low.

Top module: `dmasel_top`

## Requirements
- R1: While reset is asserted and after it is released, `mode_valid` is 0 and `mode_code` is 0 until the first start.
- R2: When `start` is high at a rising edge, `mode_valid` is high for the following cycle only and carries the result for the inputs sampled at that edge. Without a start, `mode_code` keeps its last value.
- R3: When `cap_valid[2]` is 1 and `req_mode` >= 0x40, a nonzero AND of `host_udma_mask` and `dev_udma_mask` gives 0x40 plus the index of its highest set bit. The result is always in one class: bits 7:4 of a result are 0 or one-hot.
- R4: A class whose base code (0x40, 0x20, 0x10) is above `req_mode` is skipped, and the search falls through to the next lower class.
- R5: When `cap_valid[1]` is 1 and the Ultra class gives nothing, a nonzero AND of `host_mdma_mask` and `dev_mdma_mask` gives 0x20 plus the index of its highest set bit.
- R6: `cap_valid[2]` = 0 disables the Ultra class. `cap_valid[1]` = 0 disables the multiword class and the device singleword mask. With both clear and `legacy_sw_timing` = 0, the result is 0.
- R7: When `req_mode` > 0x42 and `cable_80w` is 0, Ultra mask bits 3 to 6 are removed before the search. At `req_mode` <= 0x42 no bits are removed.
- R8: When `cap_valid[1]` is 0 and `legacy_sw_timing` is 1 or 2, the singleword mask has bits 0 up to that value set, ANDed with `host_sdma_mask`. Values 0 and 3 or more give no singleword mask.
- R9: The result never exceeds `req_mode`. A chosen code above the request is replaced by `req_mode`.
- R10: When no class yields a mode, including when `req_mode` < 0x10, the result is 0.
- R11: When `non_disk` and `no_atapi_dma` are both 1, the result is 0. Either flag alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sample the inputs and compute a result |
| req_mode | input | 8 | Requested mode code (upper limit) |
| cap_valid | input | 2 | Bit 2: Ultra masks valid; bit 1: multiword/singleword masks valid |
| host_udma_mask | input | 7 | Host Ultra DMA modes 0-6 |
| dev_udma_mask | input | 7 | Device Ultra DMA modes 0-6 |
| host_mdma_mask | input | 3 | Host multiword modes 0-2 |
| dev_mdma_mask | input | 3 | Device multiword modes 0-2 |
| host_sdma_mask | input | 3 | Host singleword modes 0-2 |
| dev_sdma_mask | input | 3 | Device singleword modes 0-2 |
| legacy_sw_timing | input | 8 | Legacy highest singleword mode, 0 = absent |
| cable_80w | input | 1 | 80-wire cable detected |
| non_disk | input | 1 | Device is not a disk |
| no_atapi_dma | input | 1 | Host forbids DMA for non-disk devices |
| mode_valid | output | 1 | One-cycle result strobe |
| mode_code | output | 8 | Selected mode code, 0 = no DMA |

## Verification
The checker assumes that every input is stable around the rising edge at which `start` is sampled. It also assumes that reset is held low across at least one clock edge. The bench changes inputs only at falling edges and raises `start` for whole cycles. It releases reset at a falling edge after several cycles. It also holds `start` across consecutive cycles with a changed request, so the `T_REPEAT` path is exercised under the same stability rule.

// File: rtl/dmasel_pkg.sv
package dmasel_pkg;
    // Width of a transfer mode code
    localparam int CODE_W = 8;

    // Base code of each transfer class, highest priority first
    localparam logic [CODE_W-1:0] UDMA_BASE = 8'h40;
    localparam logic [CODE_W-1:0] MDMA_BASE = 8'h20;
    localparam logic [CODE_W-1:0] SDMA_BASE = 8'h10;

    typedef enum logic [0:0] {
        S_IDLE    = 1'b0,
        S_PRESENT = 1'b1
    } sel_state_e;
endpackage

// File: rtl/dmasel_msb_find.sv
module dmasel_msb_find #(
    parameter int W  = 7,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Later (higher) set bits override earlier ones
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dmasel_class_mask.sv
module dmasel_class_mask #(
    parameter int W    = 3,
    parameter int KEEP = W
) (
    input  logic [W-1:0] host_mask,
    input  logic [W-1:0] dev_mask,
    input  logic         cap_ok,
    input  logic [W-1:0] alt_mask,
    input  logic         cut_en,
    output logic [W-1:0] usable
);
    // Device mask when valid, otherwise a substitute; bits at or above KEEP dropped on cut
    always_comb begin
        usable = cap_ok ? (host_mask & dev_mask) : (host_mask & alt_mask);
        if (cut_en) begin
            for (int i = KEEP; i < W; i++) begin
                usable[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dmasel_tier_pick.sv
module dmasel_tier_pick
    import dmasel_pkg::*;
#(
    parameter int UIW = 3,
    parameter int MIW = 2,
    parameter int SIW = 2
) (
    input  logic [CODE_W-1:0] req_mode,
    input  logic              inhibit,
    input  logic              u_found,
    input  logic [UIW-1:0]    u_idx,
    input  logic              m_found,
    input  logic [MIW-1:0]    m_idx,
    input  logic              s_found,
    input  logic [SIW-1:0]    s_idx,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] chosen;

    always_comb begin
        chosen = '0;
        if (req_mode >= UDMA_BASE && u_found) begin
            chosen = UDMA_BASE + CODE_W'(u_idx);
        end else if (req_mode >= MDMA_BASE && m_found) begin
            chosen = MDMA_BASE + CODE_W'(m_idx);
        end else if (req_mode >= SDMA_BASE && s_found) begin
            chosen = SDMA_BASE + CODE_W'(s_idx);
        end

        if (inhibit) begin
            code = '0;
        end else if (chosen > req_mode) begin
            code = req_mode;
        end else begin
            code = chosen;
        end
    end
endmodule

// File: rtl/dmasel_top.sv
module dmasel_top
    import dmasel_pkg::*;
#(
    parameter int UDMA_W     = 7,
    parameter int MDMA_W     = 3,
    parameter int SDMA_W     = 3,
    parameter int LEGACY_W   = 8,
    parameter int CABLE_KEEP = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CODE_W-1:0]   req_mode,
    input  logic [2:1]          cap_valid,
    input  logic [UDMA_W-1:0]   host_udma_mask,
    input  logic [UDMA_W-1:0]   dev_udma_mask,
    input  logic [MDMA_W-1:0]   host_mdma_mask,
    input  logic [MDMA_W-1:0]   dev_mdma_mask,
    input  logic [SDMA_W-1:0]   host_sdma_mask,
    input  logic [SDMA_W-1:0]   dev_sdma_mask,
    input  logic [LEGACY_W-1:0] legacy_sw_timing,
    input  logic                cable_80w,
    input  logic                non_disk,
    input  logic                no_atapi_dma,
    output logic                mode_valid,
    output logic [CODE_W-1:0]   mode_code
);
    localparam int UIW = (UDMA_W > 1) ? $clog2(UDMA_W) : 1;
    localparam int MIW = (MDMA_W > 1) ? $clog2(MDMA_W) : 1;
    localparam int SIW = (SDMA_W > 1) ? $clog2(SDMA_W) : 1;
    localparam logic [CODE_W-1:0] CUT_ABOVE = UDMA_BASE + CODE_W'(CABLE_KEEP - 1);

    sel_state_e state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] pick_code;

    // ---------------- mask preparation ----------------
    logic              ultra_cut;
    logic [SDMA_W-1:0] legacy_mask;
    logic [UDMA_W-1:0] u_usable;
    logic [MDMA_W-1:0] m_usable;
    logic [SDMA_W-1:0] s_usable;

    assign ultra_cut = (req_mode > CUT_ABOVE) && !cable_80w;

    // Legacy timing t (1..SDMA_W-1) enables singleword modes 0..t
    always_comb begin
        logic [31:0] lt;
        lt = 32'(legacy_sw_timing);
        legacy_mask = '0;
        if (lt != 32'd0 && lt < 32'(SDMA_W)) begin
            for (int i = 0; i < SDMA_W; i++) begin
                legacy_mask[i] = (32'(i) <= lt);
            end
        end
    end

    dmasel_class_mask #(.W(UDMA_W), .KEEP(CABLE_KEEP)) u_umask (
        .host_mask (host_udma_mask),
        .dev_mask  (dev_udma_mask),
        .cap_ok    (cap_valid[2]),
        .alt_mask  ('0),
        .cut_en    (ultra_cut),
        .usable    (u_usable)
    );

    dmasel_class_mask #(.W(MDMA_W), .KEEP(MDMA_W)) u_mmask (
        .host_mask (host_mdma_mask),
        .dev_mask  (dev_mdma_mask),
        .cap_ok    (cap_valid[1]),
        .alt_mask  ('0),
        .cut_en    (1'b0),
        .usable    (m_usable)
    );

    dmasel_class_mask #(.W(SDMA_W), .KEEP(SDMA_W)) u_smask (
        .host_mask (host_sdma_mask),
        .dev_mask  (dev_sdma_mask),
        .cap_ok    (cap_valid[1]),
        .alt_mask  (legacy_mask),
        .cut_en    (1'b0),
        .usable    (s_usable)
    );

    // ---------------- highest mode per class ----------------
    logic           u_found, m_found, s_found;
    logic [UIW-1:0] u_idx;
    logic [MIW-1:0] m_idx;
    logic [SIW-1:0] s_idx;

    dmasel_msb_find #(.W(UDMA_W), .IW(UIW)) u_ufind (
        .vec (u_usable), .found (u_found), .idx (u_idx)
    );
    dmasel_msb_find #(.W(MDMA_W), .IW(MIW)) u_mfind (
        .vec (m_usable), .found (m_found), .idx (m_idx)
    );
    dmasel_msb_find #(.W(SDMA_W), .IW(SIW)) u_sfind (
        .vec (s_usable), .found (s_found), .idx (s_idx)
    );

    dmasel_tier_pick #(.UIW(UIW), .MIW(MIW), .SIW(SIW)) u_pick (
        .req_mode (req_mode),
        .inhibit  (non_disk && no_atapi_dma),
        .u_found  (u_found),
        .u_idx    (u_idx),
        .m_found  (m_found),
        .m_idx    (m_idx),
        .s_found  (s_found),
        .s_idx    (s_idx),
        .code     (pick_code)
    );

    // ---------------- control ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    state_d = start ? S_PRESENT : S_IDLE;    // T_LAUNCH
            S_PRESENT: state_d = start ? S_PRESENT : S_IDLE;    // T_REPEAT / T_RETIRE
        endcase
    end

    // Output process: result register captured on every start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (start) begin
            code_q <= pick_code;
        end
    end

    assign mode_valid = (state_q == S_PRESENT);
    assign mode_code  = code_q;
endmodule

// File: rtl/dmasel_chk.sv
module dmasel_chk
    import dmasel_pkg::*;
#(
    parameter int LEGACY_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [CODE_W-1:0]   req_mode,
    input logic [2:1]          cap_valid,
    input logic [LEGACY_W-1:0] legacy_sw_timing,
    input logic                non_disk,
    input logic                no_atapi_dma,
    input logic                mode_valid,
    input logic [CODE_W-1:0]   mode_code
);
    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mode_valid);

    // R2
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |-> $past(start));

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(mode_code));

    // R9
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |-> (mode_code <= $past(req_mode)));

    // R11
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && $past(non_disk && no_atapi_dma)) |-> (mode_code == '0));

    // R3
    one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid |-> $onehot0(mode_code[7:4]));

    // R6
    no_caps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && $past(cap_valid == 2'b00 && legacy_sw_timing == '0))
            |-> (mode_code == '0));
endmodule

bind dmasel_top dmasel_chk #(.LEGACY_W(LEGACY_W)) u_dmasel_chk (.*);

// File: tb/dmasel_top_bench.sv
module dmasel_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] req_mode = 8'h00;
    logic [2:1] cap_valid = 2'b00;
    logic [6:0] host_udma_mask = '0, dev_udma_mask = '0;
    logic [2:0] host_mdma_mask = '0, dev_mdma_mask = '0;
    logic [2:0] host_sdma_mask = '0, dev_sdma_mask = '0;
    logic [7:0] legacy_sw_timing = '0;
    logic       cable_80w = 1'b0, non_disk = 1'b0, no_atapi_dma = 1'b0;
    logic       mode_valid;
    logic [7:0] mode_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dmasel_top u_dmasel_top (
        .clk(clk), .rst_n(rst_n), .start(start), .req_mode(req_mode),
        .cap_valid(cap_valid),
        .host_udma_mask(host_udma_mask), .dev_udma_mask(dev_udma_mask),
        .host_mdma_mask(host_mdma_mask), .dev_mdma_mask(dev_mdma_mask),
        .host_sdma_mask(host_sdma_mask), .dev_sdma_mask(dev_sdma_mask),
        .legacy_sw_timing(legacy_sw_timing), .cable_80w(cable_80w),
        .non_disk(non_disk), .no_atapi_dma(no_atapi_dma),
        .mode_valid(mode_valid), .mode_code(mode_code)
    );

    // Behavioural reference of the selection rules
    function automatic int top_bit(input int m);
        int r = -1;
        for (int i = 0; i < 32; i++) if (m[i]) r = i;
        return r;
    endfunction

    function automatic int model_pick();
        int req = int'(req_mode);
        int m;
        int pick = 0;
        if (non_disk && no_atapi_dma) return 0;
        if (req >= 64) begin
            m = cap_valid[2] ? int'(host_udma_mask & dev_udma_mask) : 0;
            if (req > 66 && (m & 'h78) != 0 && !cable_80w) m = m & 7;
            if (m != 0) pick = 64 + top_bit(m);
        end
        if (pick == 0 && req >= 32) begin
            m = cap_valid[1] ? int'(host_mdma_mask & dev_mdma_mask) : 0;
            if (m != 0) pick = 32 + top_bit(m);
        end
        if (pick == 0 && req >= 16) begin
            if (cap_valid[1]) m = int'(host_sdma_mask & dev_sdma_mask);
            else if (legacy_sw_timing != 0 && legacy_sw_timing <= 2)
                m = ((2 << legacy_sw_timing) - 1) & int'(host_sdma_mask);
            else m = 0;
            if (m != 0) pick = 16 + top_bit(m);
        end
        return (pick < req) ? pick : req;
    endfunction

    int m_valid = 0;
    int m_code  = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0;
            m_code  = 0;
        end else if (start) begin
            m_valid = 1;
            m_code  = model_pick();
        end else begin
            m_valid = 0;
        end
    end

    task automatic check(input string tag, input bit ok, input int got_v, input int got_c,
                         input int exp_v, input int exp_c);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: valid=%0d code=%h expected valid=%0d code=%h",
                     tag, got_v, got_c, exp_v, exp_c);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R2 timing, all rules)
    always @(negedge clk) begin
        if (!done)
            check("R2 model", (int'(mode_valid) == m_valid) && (int'(mode_code) == m_code),
                  int'(mode_valid), int'(mode_code), m_valid, m_code);
    end

    task automatic base_inputs();
        req_mode = 8'h46; cap_valid = 2'b11;
        host_udma_mask = 7'h7F; host_mdma_mask = 3'h7; host_sdma_mask = 3'h7;
        dev_udma_mask = '0; dev_mdma_mask = '0; dev_sdma_mask = '0;
        legacy_sw_timing = '0; cable_80w = 1'b1; non_disk = 1'b0; no_atapi_dma = 1'b0;
    endtask

    // Pulse start, check the strobe cycle and the hold cycle
    task automatic fire(input string tag, input logic [7:0] exp);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(tag, mode_valid === 1'b1 && mode_code === exp,
              int'(mode_valid), int'(mode_code), 1, int'(exp));
        @(negedge clk);
        check({tag, " hold R2"}, mode_valid === 1'b0 && mode_code === exp,
              int'(mode_valid), int'(mode_code), 0, int'(exp));
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", mode_valid === 1'b0 && mode_code === 8'h00,
              int'(mode_valid), int'(mode_code), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", mode_valid === 1'b0 && mode_code === 8'h00,
              int'(mode_valid), int'(mode_code), 0, 0);

        base_inputs(); dev_udma_mask = 7'h1F;                fire("R3 ultra top", 8'h44);
        base_inputs(); host_udma_mask = 7'h03; dev_udma_mask = 7'h7F;
                                                             fire("R3 host limit", 8'h41);
        base_inputs(); dev_udma_mask = 7'h08; dev_mdma_mask = 3'b011; cable_80w = 1'b0;
                                                             fire("R7 cut to mw", 8'h21);
        base_inputs(); dev_udma_mask = 7'h08; dev_mdma_mask = 3'b011;
                                                             fire("R7 cable ok", 8'h43);
        base_inputs(); dev_udma_mask = 7'h08; cable_80w = 1'b0; req_mode = 8'h42;
                                                             fire("R7 boundary", 8'h42);
        base_inputs(); dev_udma_mask = 7'h0F; cable_80w = 1'b0;
                                                             fire("R7 low bits", 8'h42);
        base_inputs(); dev_udma_mask = 7'h7F; req_mode = 8'h41;
                                                             fire("R9 clamp", 8'h41);
        base_inputs(); dev_udma_mask = 7'h7F; dev_mdma_mask = 3'h7; req_mode = 8'h22;
                                                             fire("R4 skip ultra", 8'h22);
        base_inputs(); dev_udma_mask = 7'h7F; dev_mdma_mask = 3'h7; req_mode = 8'h21;
                                                             fire("R4 clamp in mw", 8'h21);
        base_inputs(); dev_udma_mask = 7'h7F; dev_mdma_mask = 3'h7; dev_sdma_mask = 3'b001;
        req_mode = 8'h12;                                    fire("R4 skip to sw", 8'h10);
        base_inputs(); cap_valid = 2'b01; dev_udma_mask = 7'h7F; dev_mdma_mask = 3'b011;
                                                             fire("R6 no ultra", 8'h21);
        base_inputs(); cap_valid = 2'b00; dev_udma_mask = 7'h7F; dev_mdma_mask = 3'h7;
        dev_sdma_mask = 3'h7;                                fire("R6 none", 8'h00);
        base_inputs(); cap_valid = 2'b00; legacy_sw_timing = 8'd1;
                                                             fire("R8 legacy 1", 8'h11);
        base_inputs(); cap_valid = 2'b00; legacy_sw_timing = 8'd2; host_sdma_mask = 3'b101;
                                                             fire("R8 legacy 2", 8'h12);
        base_inputs(); cap_valid = 2'b00; legacy_sw_timing = 8'd3;
                                                             fire("R8 legacy 3", 8'h00);
        base_inputs(); cap_valid = 2'b01; legacy_sw_timing = 8'd2;
                                                             fire("R8 legacy ignored", 8'h00);
        base_inputs(); cap_valid = 2'b01; host_mdma_mask = 3'b011; dev_mdma_mask = 3'b110;
                                                             fire("R5 mw and", 8'h21);
        base_inputs(); dev_udma_mask = 7'h7F; dev_mdma_mask = 3'h7; dev_sdma_mask = 3'h7;
        req_mode = 8'h0F;                                    fire("R10 below all", 8'h00);
        base_inputs(); dev_udma_mask = 7'h1F; non_disk = 1'b1; no_atapi_dma = 1'b1;
                                                             fire("R11 inhibit", 8'h00);
        base_inputs(); dev_udma_mask = 7'h1F; non_disk = 1'b1;
                                                             fire("R11 non_disk only", 8'h44);
        base_inputs(); dev_udma_mask = 7'h1F; no_atapi_dma = 1'b1;
                                                             fire("R11 flag only", 8'h44);

        // Back-to-back starts with a changed request (R2)
        base_inputs(); dev_udma_mask = 7'h1F;
        @(negedge clk) start = 1'b1;
        @(negedge clk) req_mode = 8'h41;
        check("R2 burst first", mode_valid === 1'b1 && mode_code === 8'h44,
              int'(mode_valid), int'(mode_code), 1, 'h44);
        @(negedge clk) start = 1'b0;
        check("R2 burst second", mode_valid === 1'b1 && mode_code === 8'h41,
              int'(mode_valid), int'(mode_code), 1, 'h41);
        @(negedge clk);
        check("R2 burst end", mode_valid === 1'b0 && mode_code === 8'h41,
              int'(mode_valid), int'(mode_code), 0, 'h41);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule